// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 16-bit wide asynchronous static RAM inside a synchronous design. It takes the usual active-low controls (chip select, output enable, write enable, and one enable per byte lane), an address bus, and a data bus. The data bus is split into a write-data input and a read-data output. Each byte lane has its own drive-enable output, which replaces a true tri-state pin. A fast internal sampling clock watches the control pins. It turns the asynchronous write window into a single commit on the clock edge after that window closes.

Each byte lane is gated on its own. A read drives only the lanes whose byte enable is low. A write lane is active while chip select, write enable and that lane's byte enable are all low. The lane commits when that overlap ends, using the address and data sampled in the last cycle of the overlap. The depth is set by the address width: 16 address bits give 65,536 words. The default is a smaller array for quick elaboration.

Top module: `async_sram_emu`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits (65,536 words when ADDR_W is 16). Every address, including 0 and the all-ones address, stores and returns its own word.
- R2: While `cs_n` is high, `lo_drv` and `hi_drv` are 0 and no word is modified, whatever the other inputs are. This holds also straight after reset.
- R3: With `cs_n` low, `wr_n` high and `rd_n` high, both lane drive enables are 0.
- R4: With `bl_lo_n` and `bl_hi_n` both high, both lane drive enables are 0 even when the chip is selected.
- R5: With `cs_n` low, `wr_n` high and `rd_n` low, a read takes place. `lo_drv` (bits 7:0) is 1 exactly when `bl_lo_n` is low, and `hi_drv` (bits 15:8) is 1 exactly when `bl_hi_n` is low. Each driven lane shows the stored byte.
- R6: A write updates only the lanes whose byte enable is low. The other lane of the word keeps its value. `rd_n` has no effect on a write.
- R7: A lane's write ends when any of `cs_n`, `wr_n` or its byte enable goes high. The lane then commits on the next clock edge, using the address and data sampled in the last clock cycle in which the overlap was active. Earlier data values during the overlap are discarded.
- R8: While `wr_n` is low, both lane drive enables are 0.
- R9: A lane that is not driven reads as 0 on `rd_data`.
- R10: The two lanes end their writes independently. Releasing one byte enable early commits that lane with the data present at its own release. The other lane stays open and commits later with its own final data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset of the edge history |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| bl_lo_n | input | 1 | Lower byte lane enable, active low |
| bl_hi_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | 16 | Data into the array |
| rd_data | output | 16 | Data out of the array, zero on lanes not driven |
| lo_drv | output | 1 | Lower lane drive enable |
| hi_drv | output | 1 | Upper lane drive enable |

## Verification
Writes are tried with the full word, the lower lane alone and the upper lane alone. Partial writes land on words that were filled earlier, so a lane that is clobbered by mistake shows up. Reads cover every combination of byte enables, plus output enable held high. This separates the lane gating from the global float conditions. Directed sequences then end the write in three ways: by write enable, by chip select, and by one byte enable ahead of the other. They also change data in the middle of a write, and attempt a write while deselected. These show that the commit uses the last active cycle and that each lane follows its own overlap.

// File: rtl/async_sram_emu.sv
module async_sram_emu #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bl_lo_n,
  input  logic              bl_hi_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              lo_drv,
  output logic              hi_drv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0]       mem [DEPTH];
  logic [1:0]        wopen, wopen_q, commit;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;
  logic [15:0]       word;
  logic              rd_ok;

  assign wopen  = {~cs_n & ~wr_n & ~bl_hi_n, ~cs_n & ~wr_n & ~bl_lo_n};
  assign commit = wopen_q & ~wopen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wopen_q <= '0;
    else        wopen_q <= wopen;

  always_ff @(posedge clk) begin
    addr_q <= addr;
    data_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (commit[0]) mem[addr_q][7:0]  <= data_q[7:0];
    if (commit[1]) mem[addr_q][15:8] <= data_q[15:8];
  end

  assign rd_ok   = ~cs_n & wr_n & ~rd_n;
  assign lo_drv  = rd_ok & ~bl_lo_n;
  assign hi_drv  = rd_ok & ~bl_hi_n;
  assign word    = mem[addr];
  assign rd_data = {hi_drv ? word[15:8] : 8'h00, lo_drv ? word[7:0] : 8'h00};

  assert_desel_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !lo_drv && !hi_drv);
  assert_no_lanes_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_lo_n && bl_hi_n) |-> !lo_drv && !hi_drv);
  assert_write_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !lo_drv && !hi_drv);
  assert_lo_commit_after_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit[0] |-> $past(!cs_n && !wr_n && !bl_lo_n));
  assert_hi_commit_after_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] |-> $past(!cs_n && !wr_n && !bl_hi_n));
  assert_idle_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> commit == 2'b00);
endmodule

// File: tb/tb_async_sram_emu.sv
module tb_async_sram_emu;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NVEC = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, bl_lo_n = 1'b1, bl_hi_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          lo_drv, hi_drv;
  int            checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_sram_emu #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bl_lo_n(bl_lo_n), .bl_hi_n(bl_hi_n), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .lo_drv(lo_drv), .hi_drv(hi_drv));

  // {is_write, bl_lo_n, bl_hi_n, rd_n, addr[8], data[16], expected[16]}
  localparam logic [43:0] VEC [NVEC] = '{
    {4'b1001, 8'h10, 16'hA5C3, 16'h0000},
    {4'b1001, 8'h11, 16'hFFFF, 16'h0000},
    {4'b1001, 8'h12, 16'hFFFF, 16'h0000},
    {4'b1010, 8'h11, 16'h1234, 16'h0000},
    {4'b1101, 8'h12, 16'h5678, 16'h0000},
    {4'b1001, 8'h00, 16'h0F0F, 16'h0000},
    {4'b1001, 8'hFF, 16'hF00D, 16'h0000},
    {4'b1011, 8'h10, 16'h00EE, 16'h0000},
    {4'b0000, 8'h10, 16'h0000, 16'hA5EE},
    {4'b0000, 8'h11, 16'h0000, 16'hFF34},
    {4'b0000, 8'h12, 16'h0000, 16'h56FF},
    {4'b0000, 8'h00, 16'h0000, 16'h0F0F},
    {4'b0000, 8'hFF, 16'h0000, 16'hF00D},
    {4'b0010, 8'h10, 16'h0000, 16'h00EE},
    {4'b0100, 8'h11, 16'h0000, 16'hFF00},
    {4'b0001, 8'h12, 16'h0000, 16'h0000},
    {4'b0110, 8'h00, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got drv=%b data=%h, expected drv=%b data=%h",
               req, act[17:16], act[15:0], exp[17:16], exp[15:0]);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; bl_lo_n = 1'b1; bl_hi_n = 1'b1;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic lb, input logic ub, input logic oe);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; bl_lo_n = lb; bl_hi_n = ub; rd_n = oe; addr = a; wr_data = d;
    #1 check("R8", {hi_drv, lo_drv, 16'h0}, 18'h0);
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input logic lb, input logic ub,
                           input logic oe, input string req, input logic [15:0] exp);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b1; rd_n = oe; bl_lo_n = lb; bl_hi_n = ub; addr = a;
    #1 check(req, {hi_drv, lo_drv, rd_data}, {~ub & ~oe, ~lb & ~oe, exp});
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R2 reset", {hi_drv, lo_drv, rd_data}, 18'h0);
    rst_n = 1'b1;

    // R1 R5 R6 R9: table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][43])
        write_word(VEC[i][39:32], VEC[i][31:16], VEC[i][42], VEC[i][41], VEC[i][40]);
      else
        read_word(VEC[i][39:32], VEC[i][42], VEC[i][41], VEC[i][40], "R1/R5/R6/R9", VEC[i][15:0]);
    end

    // R3: selected, no write, output enable high
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; bl_lo_n = 1'b0; bl_hi_n = 1'b0; addr = 8'h10;
    #1 check("R3", {hi_drv, lo_drv, rd_data}, 18'h0);
    idle();

    // R4: both lanes disabled during an otherwise valid read
    read_word(8'h10, 1'b1, 1'b1, 1'b0, "R4", 16'h0000);

    // R2: write attempt while deselected is ignored
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; bl_lo_n = 1'b0; bl_hi_n = 1'b0; rd_n = 1'b0; addr = 8'h10; wr_data = 16'h0000;
    #1 check("R2 desel", {hi_drv, lo_drv, rd_data}, 18'h0);
    repeat (2) @(negedge clk);
    idle();
    read_word(8'h10, 1'b0, 1'b0, 1'b0, "R2 no write", 16'hA5EE);

    // R7: data changed mid-write, last active value wins
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; bl_lo_n = 1'b0; bl_hi_n = 1'b0; addr = 8'h20; wr_data = 16'h1111;
    @(negedge clk); wr_data = 16'h2222;
    @(negedge clk); idle(); wr_data = 16'h3333;
    @(negedge clk);
    read_word(8'h20, 1'b0, 1'b0, 1'b0, "R7 last data", 16'h2222);

    // R7: write ended by chip select rising, write enable still low
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; bl_lo_n = 1'b0; bl_hi_n = 1'b0; addr = 8'h21; wr_data = 16'hBEEF;
    @(negedge clk); cs_n = 1'b1; wr_data = 16'h0000;
    @(negedge clk); idle();
    read_word(8'h21, 1'b0, 1'b0, 1'b0, "R7 cs end", 16'hBEEF);

    // R10: upper lane released early, lower lane continues
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; bl_lo_n = 1'b0; bl_hi_n = 1'b0; addr = 8'h30; wr_data = 16'hABCD;
    @(negedge clk); bl_hi_n = 1'b1; wr_data = 16'h9999;
    @(negedge clk); wr_data = 16'h9977;
    @(negedge clk); idle(); wr_data = 16'h0000;
    @(negedge clk);
    read_word(8'h30, 1'b0, 1'b0, 1'b0, "R10", 16'hAB77);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule